// File: doc/BRIEF.md
# Key-unlocked EEPROM write controller

This block fronts a small on-chip data store of 256 sixteen-bit words. A host on a simple register bus can read any word at any time, but it can only change the store by running a program or erase job. A job starts from the control register, and that register only accepts a start after a two-write key sequence. This guards the store against stray writes from runaway code.

The host loads a target address and a data value into holding registers and picks an operation in the low byte of the control register. It writes 0x0055 and then 0x00AA to the write-only key register. In the cycle right after that, it writes the control register with the start bit set. The block then raises busy for a fixed, parameterised number of cycles. When the count ends it commits the job to the array and drops busy by itself. If the job was invalid, it sets an error flag instead. Bus reads and register writes keep completing while a job runs.

Top module: `nvkey_eeprom`

## Requirements
- R1: After reset the control register reads 0x0000, `busy` is low and every word of the array reads 0xFFFF.
- R2: In register space (`bus_space`=0), `bus_addr[2:0]` selects the register. 0 is control, 1 is key, 2 is target address bits 15:0, 3 is target address bits 23:16 (held in data bits 7:0) and 4 is the data latch. The key register always reads 0x0000. Offsets 2, 3 and 4 read back what was written. Offsets 5 to 7 read 0x0000.
- R3: A key write of 0x0055 followed by a key write of 0x00AA opens the unlock window. A control write with bit 15 set in the very next cycle starts a job. From the following cycle on, `busy` and control bit 15 read 1.
- R4: The window lasts one cycle only. A control write with bit 15 set in any later cycle does not start a job.
- R5: The sequence is cancelled by any bus write between the two key writes, in either space and at any offset, including a key write of any value other than 0x00AA. Cycles with no bus write leave the half-unlocked state in place. A key write of any value other than 0x0055 never begins the sequence.
- R6: A control write while locked and not busy loads data bits 7:0 into the operation-select field (control bits 7:0). It leaves bit 15 at 0.
- R7: Once started, `busy` (control bit 15) stays high for exactly BUSY_CYCLES cycles and then clears by itself. A control write during that time changes no control bit and does not restart the job.
- R8: Operation 0x02 writes the data-latch value captured at start into the word at the target address captured at start. The word keeps its old value until busy falls.
- R9: Operation 0x01 sets only the addressed word to 0xFFFF.
- R10: Operation 0x03 sets every word to 0xFFFF.
- R11: Control bit 13 is the error flag. It is set when a job ends with an operation code other than 0x01, 0x02 or 0x03. It is also set when a word operation's target lies outside the window. In both cases no word changes. Starting the next job clears the flag.
- R12: In memory space (`bus_space`=1), word k sits at 0x7FFE00+2k, and both addresses of each pair read it (bit 0 is ignored). Addresses outside 0x7FFE00 to 0x7FFFFF read 0x0000. Memory-space writes never change the array. Reads are answered in the same cycle, busy or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Bus write strobe for this cycle |
| bus_space | input | 1 | 0 selects registers, 1 selects the memory window |
| bus_addr | input | 24 | Register offset (bits 2:0) or memory-window address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address, combinational |
| busy | output | 1 | A program or erase job is running |

## Verification
The bench targets the unlock sequencer's edges. It leaves one idle cycle before the control write, reverses the two keys, slips a data-latch write or a memory-space write between them, and leaves idle gaps between them. A sequencer that held its window open too long, or that was not cancelled by a stray write, would start a job the test expects to stay locked. It also checks that a control write during a job neither restarts the job nor edits the operation field. A design without a snapshot would commit a data value written mid-job, or would stretch busy beyond BUSY_CYCLES. An out-of-window target whose low bits alias a real word catches a missing range check, which would corrupt word 4 instead of raising the error flag. Reads at both ends of the window and just past them catch an off-by-one in the address decode.

// File: rtl/nvk_pkg.sv
package nvk_pkg;

  // register offsets inside register space
  localparam logic [2:0] OFF_CTL  = 3'd0;
  localparam logic [2:0] OFF_KEY  = 3'd1;
  localparam logic [2:0] OFF_ADRL = 3'd2;
  localparam logic [2:0] OFF_ADRH = 3'd3;
  localparam logic [2:0] OFF_DATA = 3'd4;

  // control register layout
  localparam int CTL_W       = 16;
  localparam int CTL_GO_BIT  = 15;
  localparam int CTL_ERR_BIT = 13;
  localparam int OPSEL_W     = 8;

  // operation codes
  localparam logic [OPSEL_W-1:0] OP_ERASE_WORD = 8'h01;
  localparam logic [OPSEL_W-1:0] OP_PROG_WORD  = 8'h02;
  localparam logic [OPSEL_W-1:0] OP_ERASE_ALL  = 8'h03;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_HALF = 2'd1,
    UL_OPEN = 2'd2
  } ul_state_t;

  function automatic logic op_known(input logic [OPSEL_W-1:0] op);
    return (op == OP_ERASE_WORD) || (op == OP_PROG_WORD) || (op == OP_ERASE_ALL);
  endfunction

  function automatic logic op_is_word(input logic [OPSEL_W-1:0] op);
    return (op == OP_ERASE_WORD) || (op == OP_PROG_WORD);
  endfunction

  function automatic logic [CTL_W-1:0] ctl_word(input logic go, input logic err,
                                                input logic [OPSEL_W-1:0] op);
    logic [CTL_W-1:0] w;
    w = '0;
    w[CTL_GO_BIT]    = go;
    w[CTL_ERR_BIT]   = err;
    w[OPSEL_W-1:0]   = op;
    return w;
  endfunction

endpackage

// File: rtl/nvk_unlock.sv
module nvk_unlock
  import nvk_pkg::*;
#(
  parameter int          KW    = 16,
  parameter logic [KW-1:0] KEY_A = 16'h0055,
  parameter logic [KW-1:0] KEY_B = 16'h00AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_wr_i,
  input  logic          key_wr_i,
  input  logic [KW-1:0] key_val_i,
  output logic          open_o
);

  ul_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      UL_IDLE: if (key_wr_i && key_val_i == KEY_A) state_d = UL_HALF;
      UL_HALF: if (any_wr_i) state_d = (key_wr_i && key_val_i == KEY_B) ? UL_OPEN : UL_IDLE;
      UL_OPEN: state_d = UL_IDLE;
      default: state_d = UL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= UL_IDLE;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == UL_OPEN);

endmodule

// File: rtl/nvk_busy.sv
module nvk_busy #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));

endmodule

// File: rtl/nvk_store.sv
module nvk_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 256,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_all_i,
  input  logic          wr_one_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_val_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_val_o
);

  localparam logic [DW-1:0] ERASED = {DW{1'b1}};

  logic [DW-1:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= ERASED;
    end else if (wr_all_i) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= ERASED;
    end else if (wr_one_i) begin
      cell_q[wr_idx_i] <= wr_val_i;
    end
  end

  assign rd_val_o = cell_q[rd_idx_i];

endmodule

// File: rtl/nvkey_eeprom.sv
module nvkey_eeprom
  import nvk_pkg::*;
#(
  parameter int            AW          = 24,
  parameter int            DW          = 16,
  parameter int            DEPTH       = 256,
  parameter int            STEP_LOG2   = 1,
  parameter logic [AW-1:0] BASE        = 24'h7FFE00,
  parameter int            BUSY_CYCLES = 8,
  parameter logic [DW-1:0] KEY_A       = 16'h0055,
  parameter logic [DW-1:0] KEY_B       = 16'h00AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_space,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          busy
);

  localparam int            IW    = $clog2(DEPTH);
  localparam int            HIW   = AW - DW;
  localparam logic [AW-1:0] SPAN  = AW'(DEPTH) << STEP_LOG2;
  localparam logic [DW-1:0] ONES  = {DW{1'b1}};

  // address arithmetic for the memory window
  function automatic logic in_window(input logic [AW-1:0] a);
    logic [AW-1:0] off;
    off = a - BASE;
    return (a >= BASE) && (off < SPAN);
  endfunction

  function automatic logic [IW-1:0] word_index(input logic [AW-1:0] a);
    logic [AW-1:0] off;
    off = (a - BASE) >> STEP_LOG2;
    return off[IW-1:0];
  endfunction

  // bus decode
  logic       reg_we, ctl_wr, key_wr;
  logic [2:0] reg_off;

  assign reg_we  = bus_we && !bus_space;
  assign reg_off = bus_addr[2:0];
  assign ctl_wr  = reg_we && (reg_off == OFF_CTL);
  assign key_wr  = reg_we && (reg_off == OFF_KEY);

  // named internal events
  logic ul_open;
  logic start_ev;
  logic commit_ev;
  logic commit_bad;

  nvk_unlock #(.KW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) i_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_wr_i  (bus_we),
    .key_wr_i  (key_wr),
    .key_val_i (bus_wdata),
    .open_o    (ul_open)
  );

  assign start_ev = ctl_wr && ul_open && !busy && bus_wdata[CTL_GO_BIT];

  nvk_busy #(.CYCLES(BUSY_CYCLES)) i_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_ev),
    .busy_o  (busy),
    .done_o  (commit_ev)
  );

  // host-visible registers
  logic [OPSEL_W-1:0] op_q;
  logic               err_q;
  logic [AW-1:0]      adr_q;
  logic [DW-1:0]      dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      adr_q <= '0;
      dat_q <= '0;
    end else if (reg_we) begin
      unique case (reg_off)
        OFF_CTL:  if (!busy) op_q <= bus_wdata[OPSEL_W-1:0];
        OFF_ADRL: adr_q[DW-1:0]  <= bus_wdata;
        OFF_ADRH: adr_q[AW-1:DW] <= bus_wdata[HIW-1:0];
        OFF_DATA: dat_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  // job snapshot taken at start
  logic [OPSEL_W-1:0] job_op;
  logic [AW-1:0]      job_adr;
  logic [DW-1:0]      job_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      job_op  <= '0;
      job_adr <= '0;
      job_dat <= '0;
    end else if (start_ev) begin
      job_op  <= bus_wdata[OPSEL_W-1:0];
      job_adr <= adr_q;
      job_dat <= dat_q;
    end
  end

  logic job_in_win;
  assign job_in_win = in_window(job_adr);
  assign commit_bad = commit_ev && (!op_known(job_op) || (op_is_word(job_op) && !job_in_win));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (start_ev)   err_q <= 1'b0;
    else if (commit_bad) err_q <= 1'b1;
  end

  // array commit
  logic          st_wr_all, st_wr_one;
  logic [DW-1:0] st_wr_val, st_rd_val;

  assign st_wr_all = commit_ev && (job_op == OP_ERASE_ALL);
  assign st_wr_one = commit_ev && op_is_word(job_op) && job_in_win;
  assign st_wr_val = (job_op == OP_ERASE_WORD) ? ONES : job_dat;

  nvk_store #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_all_i (st_wr_all),
    .wr_one_i (st_wr_one),
    .wr_idx_i (word_index(job_adr)),
    .wr_val_i (st_wr_val),
    .rd_idx_i (word_index(bus_addr)),
    .rd_val_o (st_rd_val)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_space) begin
      if (in_window(bus_addr)) bus_rdata = st_rd_val;
    end else begin
      unique case (reg_off)
        OFF_CTL:  bus_rdata = DW'(ctl_word(busy, err_q, op_q));
        OFF_ADRL: bus_rdata = adr_q[DW-1:0];
        OFF_ADRH: bus_rdata = {{(DW-HIW){1'b0}}, adr_q[AW-1:DW]};
        OFF_DATA: bus_rdata = dat_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/nvk_chk.sv
module nvk_chk #(
  parameter int            DW          = 16,
  parameter int            BUSY_CYCLES = 8,
  parameter logic [DW-1:0] KEY_B       = 16'h00AA
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          ul_open,
  input logic          commit_ev,
  input logic          key_wr,
  input logic [DW-1:0] key_val,
  input logic          err_q,
  input logic [7:0]    op_q
);

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  // R3
  start_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ul_open));

  // R3
  window_after_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ul_open) |-> ($past(key_wr) && $past(key_val) == KEY_B));

  // R4
  window_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ul_open |=> !ul_open);

  // R7
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit_ev) |=> busy);

  // R7
  busy_ends_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(commit_ev));

  // R7
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= BUSY_CYCLES);

  // R7
  opsel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(op_q));

  // R11
  err_only_at_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(commit_ev));

endmodule

bind nvkey_eeprom nvk_chk #(
  .DW(DW), .BUSY_CYCLES(BUSY_CYCLES), .KEY_B(KEY_B)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .ul_open   (ul_open),
  .commit_ev (commit_ev),
  .key_wr    (key_wr),
  .key_val   (bus_wdata),
  .err_q     (err_q),
  .op_q      (op_q)
);

// File: tb/test_nvkey_eeprom.sv
module test_nvkey_eeprom;

  localparam int          CLK_PERIOD = 10;
  localparam int          BUSY       = 8;
  localparam logic [23:0] BASE       = 24'h7FFE00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_space = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvkey_eeprom #(.BUSY_CYCLES(BUSY)) i_nvkey_eeprom (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_space(bus_space),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    finished = 0;
  string cur_req = "R1";
  logic [15:0] last_rd;
  logic        last_busy;

  // reference model state
  int          m_lock = 0;
  int          m_cnt  = 0;
  logic [7:0]  m_op   = '0;
  logic        m_err  = 1'b0;
  logic [23:0] m_adr  = '0;
  logic [15:0] m_dat  = '0;
  logic [7:0]  j_op   = '0;
  logic [23:0] j_adr  = '0;
  logic [15:0] j_dat  = '0;
  logic [15:0] m_mem [256];

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit inwin(input logic [23:0] a);
    return (a >= BASE) && ((a - BASE) < 24'd512);
  endfunction

  function automatic int widx(input logic [23:0] a);
    return int'((a - BASE) / 2);
  endfunction

  function automatic logic [15:0] model_rd(input logic sp, input logic [23:0] a);
    if (sp) return inwin(a) ? m_mem[widx(a)] : 16'h0000;
    case (int'(a[2:0]))
      0: return {m_cnt > 0, 1'b0, m_err, 5'b0, m_op};
      2: return m_adr[15:0];
      3: return {8'h00, m_adr[23:16]};
      4: return m_dat;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_commit();
    case (j_op)
      8'h01: if (inwin(j_adr)) m_mem[widx(j_adr)] = 16'hFFFF; else m_err = 1'b1;
      8'h02: if (inwin(j_adr)) m_mem[widx(j_adr)] = j_dat;    else m_err = 1'b1;
      8'h03: for (int i = 0; i < 256; i++) m_mem[i] = 16'hFFFF;
      default: m_err = 1'b1;
    endcase
  endtask

  task automatic model_step(input logic sp, input logic we, input logic [23:0] a, input logic [15:0] wd);
    bit was_busy = (m_cnt > 0);
    int pre_lock = m_lock;
    bit regw     = we && !sp;
    int off      = int'(a[2:0]);
    if (was_busy) begin
      m_cnt--;
      if (m_cnt == 0) model_commit();
    end
    if (regw) begin
      case (off)
        0: if (!was_busy) begin
             m_op = wd[7:0];
             if (pre_lock == 2 && wd[15]) begin
               m_cnt = BUSY; m_err = 1'b0;
               j_op = wd[7:0]; j_adr = m_adr; j_dat = m_dat;
             end
           end
        2: m_adr[15:0]  = wd;
        3: m_adr[23:16] = wd[7:0];
        4: m_dat = wd;
        default: ;
      endcase
    end
    case (pre_lock)
      0: if (regw && off == 1 && wd == 16'h0055) m_lock = 1;
      1: if (we) m_lock = (regw && off == 1 && wd == 16'h00AA) ? 2 : 0;
      default: m_lock = 0;
    endcase
  endtask

  // one bus cycle, compared against the model on every clock
  task automatic cyc(input logic sp, input logic we, input logic [23:0] a, input logic [15:0] wd);
    @(negedge clk);
    last_busy = busy;
    chk(busy === (m_cnt > 0), "R7", {15'b0, busy}, {15'b0, m_cnt > 0});
    bus_space = sp; bus_we = we; bus_addr = a; bus_wdata = wd;
    #1;
    last_rd = bus_rdata;
    chk(last_rd === model_rd(sp, a), cur_req, last_rd, model_rd(sp, a));
    model_step(sp, we, a, wd);
  endtask

  task automatic idle();                                         cyc(1'b0, 1'b0, 24'h0, 16'h0); endtask
  task automatic wreg(input logic [2:0] off, input logic [15:0] v); cyc(1'b0, 1'b1, {21'b0, off}, v); endtask
  task automatic rreg(input logic [2:0] off, input logic [15:0] exp, input string req);
    cyc(1'b0, 1'b0, {21'b0, off}, 16'h0);
    chk(last_rd === exp, req, last_rd, exp);
  endtask
  task automatic rmem(input logic [23:0] a, input logic [15:0] exp, input string req);
    cyc(1'b1, 1'b0, a, 16'h0);
    chk(last_rd === exp, req, last_rd, exp);
  endtask
  task automatic unlock(); wreg(3'd1, 16'h0055); wreg(3'd1, 16'h00AA); endtask
  task automatic wait_done();
    for (int i = 0; i < 40 && m_cnt > 0; i++) idle();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 16'hFFFF;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cur_req = "R1";
    rreg(3'd0, 16'h0000, "R1");
    chk(last_busy === 1'b0, "R1", {15'b0, last_busy}, 16'h0);
    rmem(BASE, 16'hFFFF, "R1");
    rmem(24'h7FFFFE, 16'hFFFF, "R1");

    // R2 register map
    cur_req = "R2";
    wreg(3'd2, 16'hFE0A); wreg(3'd3, 16'h007F); wreg(3'd4, 16'h1234);
    rreg(3'd2, 16'hFE0A, "R2");
    rreg(3'd3, 16'h007F, "R2");
    rreg(3'd4, 16'h1234, "R2");
    wreg(3'd1, 16'h3333);
    rreg(3'd1, 16'h0000, "R2");
    rreg(3'd6, 16'h0000, "R2");

    // R3 / R8 program word 5, with traffic during the job
    cur_req = "R3";
    unlock(); wreg(3'd0, 16'h8002);
    rreg(3'd0, 16'h8002, "R3");
    chk(last_busy === 1'b1, "R3", {15'b0, last_busy}, 16'h1);
    cur_req = "R7";
    wreg(3'd0, 16'h0001);
    rreg(3'd0, 16'h8002, "R7");
    wreg(3'd4, 16'h9999);
    cur_req = "R12";
    rmem(BASE + 24'd10, 16'hFFFF, "R12");
    cyc(1'b1, 1'b1, BASE + 24'd12, 16'h0000);
    wait_done();
    rmem(BASE + 24'd10, 16'h1234, "R8");
    rmem(BASE + 24'd12, 16'hFFFF, "R12");
    rreg(3'd0, 16'h0002, "R7");

    // R7 exact busy length
    cur_req = "R7";
    wreg(3'd4, 16'h00AB);
    unlock(); wreg(3'd0, 16'h8002);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      idle();
      if (last_busy) n++;
    end
    chk(n == BUSY, "R7", 16'(n), 16'(BUSY));
    rmem(BASE + 24'd10, 16'h00AB, "R8");

    // R9 erase one word, neighbour untouched
    cur_req = "R9";
    wreg(3'd2, 16'hFE08); wreg(3'd4, 16'h4444);
    unlock(); wreg(3'd0, 16'h8002); wait_done();
    wreg(3'd2, 16'hFE0A);
    unlock(); wreg(3'd0, 16'h8001); wait_done();
    rmem(BASE + 24'd10, 16'hFFFF, "R9");
    rmem(BASE + 24'd8,  16'h4444, "R9");

    // R4 / R6 window closes after one cycle
    cur_req = "R4";
    unlock(); idle(); wreg(3'd0, 16'h8042);
    rreg(3'd0, 16'h0042, "R6");
    chk(last_busy === 1'b0, "R4", {15'b0, last_busy}, 16'h0);

    // R5 cancelled sequences
    cur_req = "R5";
    wreg(3'd1, 16'h00AA); wreg(3'd1, 16'h0055); wreg(3'd0, 16'h8002);
    rreg(3'd0, 16'h0002, "R5");
    chk(last_busy === 1'b0, "R5", {15'b0, last_busy}, 16'h0);
    wreg(3'd1, 16'h0055); wreg(3'd4, 16'h4444); wreg(3'd1, 16'h00AA); wreg(3'd0, 16'h8002);
    rreg(3'd0, 16'h0002, "R5");
    wreg(3'd1, 16'h0055); cyc(1'b1, 1'b1, BASE, 16'h0000); wreg(3'd1, 16'h00AA); wreg(3'd0, 16'h8001);
    rreg(3'd0, 16'h0001, "R5");
    wreg(3'd1, 16'h0055); wreg(3'd1, 16'h0055); wreg(3'd1, 16'h00AA); wreg(3'd0, 16'h8002);
    rreg(3'd0, 16'h0002, "R5");
    wreg(3'd1, 16'h0055); idle(); idle(); wreg(3'd1, 16'h00AA); wreg(3'd0, 16'h8001);
    rreg(3'd0, 16'h8001, "R5");
    wait_done();

    // R11 bad code and out-of-window target
    cur_req = "R11";
    unlock(); wreg(3'd0, 16'h8007); wait_done();
    rreg(3'd0, 16'h2007, "R11");
    rmem(BASE + 24'd8, 16'h4444, "R11");
    wreg(3'd3, 16'h0000); wreg(3'd2, 16'h0008); wreg(3'd4, 16'h7777);
    unlock(); wreg(3'd0, 16'h8002); wait_done();
    rreg(3'd0, 16'h2002, "R11");
    rmem(BASE + 24'd8, 16'h4444, "R11");
    wreg(3'd3, 16'h007F); wreg(3'd2, 16'hFE0A);
    unlock(); wreg(3'd0, 16'h8002);
    rreg(3'd0, 16'h8002, "R11");
    wait_done();
    rmem(BASE + 24'd10, 16'h7777, "R8");

    // R12 window edges
    cur_req = "R12";
    rmem(24'h00000A, 16'h0000, "R12");
    rmem(BASE + 24'd11, 16'h7777, "R12");
    wreg(3'd2, 16'hFFFE); wreg(3'd4, 16'hBEEF);
    unlock(); wreg(3'd0, 16'h8002); wait_done();
    rmem(24'h7FFFFF, 16'hBEEF, "R12");
    rmem(24'h7FFDFF, 16'h0000, "R12");
    rmem(24'h800000, 16'h0000, "R12");

    // R10 erase all
    cur_req = "R10";
    unlock(); wreg(3'd0, 16'h8003); wait_done();
    rmem(BASE + 24'd8,  16'hFFFF, "R10");
    rmem(BASE + 24'd10, 16'hFFFF, "R10");
    rmem(24'h7FFFFE,    16'hFFFF, "R10");
    rreg(3'd0, 16'h0003, "R10");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule